// File: doc/BRIEF.md
# Segmented Logical-to-Linear Address Translator

This block converts a logical address (a 16-bit segment selector together with a 32-bit offset) into a flat 32-bit linear address. It keeps a small bank of segment registers. Each register holds a selector and a hidden copy of the descriptor that selector names: base, limit, and read and write permission bits. Software loads a register by presenting a new selector. The block then fetches the 8-byte descriptor from the global or the local descriptor table through a 32-bit memory read port. It stores the descriptor only if the fetch succeeds.

Translation requests name a segment register, an offset, an access size of 1 to 4 bytes and a read/write flag. The block checks the cached rights and the cached limit, then adds the base to the offset. It never goes to memory on this path. One cycle after a request is accepted, the block returns either a linear address or a fault code.

The load port, the translation request port and the memory request port all use valid/ready handshakes. A transfer happens in a cycle where both valid and ready are high. A master holding valid must keep its payload stable until it sees ready.
- `ld_ready` is low for the whole length of a descriptor fetch.
- `xr_ready` is low only when the request names the register being loaded.
- The block holds `mem_rd_addr` steady while `mem_rd_ready` is low.

The result outputs (`ld_done`/`ld_fault` and `xo_valid`) are single-cycle pulses that cannot be back-pressured. The memory response is accepted in any cycle it arrives.

Top module: `seg_xlate`

## Requirements
- R1: After reset every segment register holds base 0, limit FFFFFFFFH, and both read and write permission. At that point `ld_ready` and `xr_ready` are high, and `xo_valid`, `ld_done`, `ld_fault` and `mem_rd_valid` are low.
- R2: A selector is decoded as follows: bits [15:3] are the table index, bit 2 picks the local table (1) or the global table (0), and bits [1:0] are stored and otherwise ignored. The fetch issues exactly two reads, first at table_base + index*8 and then at table_base + index*8 + 4.
- R3: An index not below the selected table's entry count raises `ld_fault` with `ld_code` = 1 one cycle after acceptance. No memory read is issued and the register is left unchanged.
- R4: Descriptor format: word 0 is the base. In word 1, bits [31:4] are limit bits [31:4] (limit bits [3:0] read as 1), bit 0 is present, bit 1 is readable and bit 2 is writable. A descriptor that is not present raises `ld_fault` with `ld_code` = 2 and leaves the register unchanged.
- R5: A successful load pulses `ld_done` one cycle after the second read response arrives. Later translations through that register use the cached descriptor and issue no memory read.
- R6: A translation pulses `xo_valid` one cycle after acceptance. With no fault, `xo_lin` = base + offset modulo 2^32 and `xo_fault` = 0.
- R7: With `xr_size` encoding bytes-1, an access whose offset + xr_size exceeds the limit (compared without wrap) gives `xo_fault` = 1 and `xo_lin` = 0.
- R8: A write to a non-writable segment, or a read of a non-readable one, gives `xo_fault` = 2 and `xo_lin` = 0. This check takes priority over the limit check.
- R9: While a fetch is in progress, `ld_ready` is low and `xr_ready` is low for requests to the target register. Requests to other registers are still accepted and translated.
- R10: While `mem_rd_valid` is high and `mem_rd_ready` is low, `mem_rd_valid` stays high and `mem_rd_addr` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gdt_base | input | 32 | Global table base address |
| gdt_count | input | 14 | Global table entry count |
| ldt_base | input | 32 | Local table base address |
| ldt_count | input | 14 | Local table entry count |
| ld_valid | input | 1 | Selector load request valid |
| ld_ready | output | 1 | Load request accepted when high |
| ld_seg | input | SEG_W (2) | Segment register to load |
| ld_sel | input | 16 | New selector |
| ld_done | output | 1 | Load completed pulse |
| ld_fault | output | 1 | Load fault pulse |
| ld_code | output | 2 | Load fault code: 1 range, 2 not present |
| mem_rd_valid | output | 1 | Memory read request valid |
| mem_rd_ready | input | 1 | Memory read request accepted |
| mem_rd_addr | output | 32 | Memory read byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| xr_valid | input | 1 | Translation request valid |
| xr_ready | output | 1 | Translation request accepted when high |
| xr_seg | input | SEG_W (2) | Segment register used |
| xr_off | input | 32 | Offset |
| xr_size | input | 2 | Access bytes minus one |
| xr_write | input | 1 | 1 for write access |
| xo_valid | output | 1 | Translation result pulse |
| xo_lin | output | 32 | Linear address, 0 on fault |
| xo_fault | output | 2 | 0 none, 1 limit, 2 rights |

## Verification
A corrupted cached descriptor does not show up when the load completes. It shows up at the first translation through that register: a wrong `xo_lin`, or a limit or rights fault where none is expected (or the reverse). Finding it may take many cycles, so the bench keeps a shadow copy of every register and checks every translation against it. A wrong fetch state shows up more quickly. Within the same load it appears as an unexpected read address, a read count other than two, a missing or doubled result pulse, or `ld_ready`/`xr_ready` stuck low.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int LIN_W = 32;
  localparam int SEL_W = 16;
  localparam int IDX_W = 13;
  localparam int CNT_W = IDX_W + 1;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic [LIN_W-1:0] base;
    logic [LIN_W-1:0] limit;
    logic             rd_ok;
    logic             wr_ok;
  } seg_desc_t;

  typedef enum logic [1:0] {
    XF_NONE   = 2'd0,
    XF_LIMIT  = 2'd1,
    XF_RIGHTS = 2'd2
  } xfault_e;

  typedef enum logic [1:0] {
    LF_NONE   = 2'd0,
    LF_RANGE  = 2'd1,
    LF_ABSENT = 2'd2
  } lfault_e;

  localparam int DW1_PRESENT = 0;
  localparam int DW1_READ    = 1;
  localparam int DW1_WRITE   = 2;
endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode
  import seg_xlate_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic [LIN_W-1:0] gbl_base,
  input  logic [CNT_W-1:0] gbl_count,
  input  logic [LIN_W-1:0] loc_base,
  input  logic [CNT_W-1:0] loc_count,
  output logic [LIN_W-1:0] tbl_addr,
  output logic             in_range
);
  logic [IDX_W-1:0] idx;
  logic             use_loc;
  logic [LIN_W-1:0] base_sel;
  logic [CNT_W-1:0] count_sel;

  always_comb begin
    idx       = sel[SEL_W-1:3];
    use_loc   = sel[2];
    base_sel  = use_loc ? loc_base : gbl_base;
    count_sel = use_loc ? loc_count : gbl_count;
    tbl_addr  = base_sel + {{(LIN_W-IDX_W-3){1'b0}}, idx, 3'b000};
    in_range  = {1'b0, idx} < count_sel;
  end
endmodule

// File: rtl/seg_fetch.sv
module seg_fetch
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  input  logic [SEG_W-1:0] ld_seg,
  input  logic [SEL_W-1:0] ld_sel,
  input  logic [LIN_W-1:0] dec_addr,
  input  logic             dec_ok,
  output logic             ld_ready,
  output logic             busy,
  output logic [SEG_W-1:0] tgt_seg,
  output logic             mem_rd_valid,
  input  logic             mem_rd_ready,
  output logic [LIN_W-1:0] mem_rd_addr,
  input  logic             mem_rsp_valid,
  input  logic [LIN_W-1:0] mem_rsp_data,
  output logic             wr_en,
  output logic [SEG_W-1:0] wr_seg,
  output seg_desc_t        wr_desc,
  output logic             ld_done,
  output logic             ld_fault,
  output lfault_e          ld_code
);
  typedef enum logic [2:0] {S_IDLE, S_RD0, S_W0, S_RD1, S_W1} fstate_e;

  fstate_e          state;
  logic [LIN_W-1:0] addr_q;
  logic [SEG_W-1:0] seg_q;
  logic [SEL_W-1:0] sel_q;
  logic [LIN_W-1:0] base_q;

  always_comb begin
    ld_ready     = (state == S_IDLE);
    busy         = (state != S_IDLE);
    tgt_seg      = seg_q;
    mem_rd_valid = (state == S_RD0) || (state == S_RD1);
    mem_rd_addr  = (state == S_RD1) ? addr_q + 32'd4 : addr_q;
    wr_en        = (state == S_W1) && mem_rsp_valid && mem_rsp_data[DW1_PRESENT];
    wr_seg       = seg_q;
    wr_desc.sel   = sel_q;
    wr_desc.base  = base_q;
    wr_desc.limit = {mem_rsp_data[LIN_W-1:4], 4'hF};
    wr_desc.rd_ok = mem_rsp_data[DW1_READ];
    wr_desc.wr_ok = mem_rsp_data[DW1_WRITE];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      addr_q   <= '0;
      seg_q    <= '0;
      sel_q    <= '0;
      base_q   <= '0;
      ld_done  <= 1'b0;
      ld_fault <= 1'b0;
      ld_code  <= LF_NONE;
    end else begin
      ld_done  <= 1'b0;
      ld_fault <= 1'b0;
      case (state)
        S_IDLE: if (ld_valid) begin
          if (!dec_ok) begin
            ld_fault <= 1'b1;
            ld_code  <= LF_RANGE;
          end else begin
            addr_q <= dec_addr;
            seg_q  <= ld_seg;
            sel_q  <= ld_sel;
            state  <= S_RD0;
          end
        end
        S_RD0: if (mem_rd_ready) state <= S_W0;
        S_W0: if (mem_rsp_valid) begin
          base_q <= mem_rsp_data;
          state  <= S_RD1;
        end
        S_RD1: if (mem_rd_ready) state <= S_W1;
        S_W1: if (mem_rsp_valid) begin
          state <= S_IDLE;
          if (mem_rsp_data[DW1_PRESENT]) begin
            ld_done <= 1'b1;
            ld_code <= LF_NONE;
          end else begin
            ld_fault <= 1'b1;
            ld_code  <= LF_ABSENT;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  assert_single_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld_done, ld_fault}));

  assert_write_then_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ld_done && ld_ready));

  assert_no_read_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !ld_ready);
endmodule

// File: rtl/seg_file.sv
module seg_file
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEGS = 4,
  parameter int SEG_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_seg,
  input  seg_desc_t        wr_desc,
  input  logic [SEG_W-1:0] rd_seg,
  output seg_desc_t        rd_desc
);
  seg_desc_t regs [NUM_SEGS];

  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regs[g].sel   <= '0;
        regs[g].base  <= '0;
        regs[g].limit <= '1;
        regs[g].rd_ok <= 1'b1;
        regs[g].wr_ok <= 1'b1;
      end else if (wr_en && (wr_seg == SEG_W'(g))) begin
        regs[g] <= wr_desc;
      end
    end
  end

  always_comb begin
    rd_desc = regs[0];
    for (int i = 0; i < NUM_SEGS; i++)
      if (rd_seg == SEG_W'(i)) rd_desc = regs[i];
  end
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  seg_desc_t        desc,
  input  logic [LIN_W-1:0] off,
  input  logic [1:0]       size,
  input  logic             write,
  output logic             xo_valid,
  output logic [LIN_W-1:0] xo_lin,
  output xfault_e          xo_fault
);
  logic           rights_ok;
  logic [LIN_W:0] last_byte;
  logic           over;

  always_comb begin
    rights_ok = write ? desc.wr_ok : desc.rd_ok;
    last_byte = {1'b0, off} + {{(LIN_W-1){1'b0}}, size};
    over      = last_byte > {1'b0, desc.limit};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xo_valid <= 1'b0;
      xo_lin   <= '0;
      xo_fault <= XF_NONE;
    end else begin
      xo_valid <= fire;
      xo_lin   <= '0;
      xo_fault <= XF_NONE;
      if (fire) begin
        if (!rights_ok)  xo_fault <= XF_RIGHTS;
        else if (over)   xo_fault <= XF_LIMIT;
        else             xo_lin   <= desc.base + off;
      end
    end
  end

  assert_fault_hides_lin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xo_fault != XF_NONE) |-> (xo_lin == '0 && xo_valid));

  assert_result_follows_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> xo_valid);
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEGS = 4,
  localparam int SEG_W = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      gdt_base,
  input  logic [13:0]      gdt_count,
  input  logic [31:0]      ldt_base,
  input  logic [13:0]      ldt_count,
  input  logic             ld_valid,
  output logic             ld_ready,
  input  logic [SEG_W-1:0] ld_seg,
  input  logic [15:0]      ld_sel,
  output logic             ld_done,
  output logic             ld_fault,
  output logic [1:0]       ld_code,
  output logic             mem_rd_valid,
  input  logic             mem_rd_ready,
  output logic [31:0]      mem_rd_addr,
  input  logic             mem_rsp_valid,
  input  logic [31:0]      mem_rsp_data,
  input  logic             xr_valid,
  output logic             xr_ready,
  input  logic [SEG_W-1:0] xr_seg,
  input  logic [31:0]      xr_off,
  input  logic [1:0]       xr_size,
  input  logic             xr_write,
  output logic             xo_valid,
  output logic [31:0]      xo_lin,
  output logic [1:0]       xo_fault
);
  logic [LIN_W-1:0] dec_addr;
  logic             dec_ok;
  logic             busy;
  logic [SEG_W-1:0] tgt_seg;
  logic             wr_en;
  logic [SEG_W-1:0] wr_seg;
  seg_desc_t        wr_desc;
  seg_desc_t        rd_desc;
  lfault_e          ld_code_e;
  xfault_e          xo_fault_e;
  logic             xr_fire;

  seg_sel_decode u_dec (
    .sel(ld_sel), .gbl_base(gdt_base), .gbl_count(gdt_count),
    .loc_base(ldt_base), .loc_count(ldt_count),
    .tbl_addr(dec_addr), .in_range(dec_ok)
  );

  seg_fetch #(.SEG_W(SEG_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_seg(ld_seg), .ld_sel(ld_sel),
    .dec_addr(dec_addr), .dec_ok(dec_ok), .ld_ready(ld_ready), .busy(busy),
    .tgt_seg(tgt_seg), .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .wr_en(wr_en), .wr_seg(wr_seg), .wr_desc(wr_desc),
    .ld_done(ld_done), .ld_fault(ld_fault), .ld_code(ld_code_e)
  );

  seg_file #(.NUM_SEGS(NUM_SEGS), .SEG_W(SEG_W)) u_file (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_seg(wr_seg), .wr_desc(wr_desc),
    .rd_seg(xr_seg), .rd_desc(rd_desc)
  );

  always_comb begin
    xr_ready = !(busy && (xr_seg == tgt_seg));
    xr_fire  = xr_valid && xr_ready;
    ld_code  = ld_code_e;
    xo_fault = xo_fault_e;
  end

  seg_check u_chk (
    .clk(clk), .rst_n(rst_n), .fire(xr_fire), .desc(rd_desc), .off(xr_off),
    .size(xr_size), .write(xr_write),
    .xo_valid(xo_valid), .xo_lin(xo_lin), .xo_fault(xo_fault_e)
  );

  assert_stall_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !(xr_fire && (xr_seg == wr_seg)));
endmodule

// File: tb/test_seg_xlate.sv
module test_seg_xlate;
  localparam logic [31:0] GB = 32'h0000_1000;
  localparam logic [31:0] LB = 32'h0000_2000;
  localparam int GCNT = 6;
  localparam int LCNT = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        ld_valid = 0, ld_ready, ld_done, ld_fault;
  logic [1:0]  ld_seg = 0, ld_code;
  logic [15:0] ld_sel = 0;
  logic        mem_rd_valid, mem_rd_ready, mem_rsp_valid;
  logic [31:0] mem_rd_addr, mem_rsp_data;
  logic        xr_valid = 0, xr_ready, xr_write = 0, xo_valid;
  logic [1:0]  xr_seg = 0, xr_size = 0, xo_fault;
  logic [31:0] xr_off = 0, xo_lin;

  seg_xlate i_seg_xlate (
    .clk(clk), .rst_n(rst_n), .gdt_base(GB), .gdt_count(14'(GCNT)),
    .ldt_base(LB), .ldt_count(14'(LCNT)),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_seg(ld_seg), .ld_sel(ld_sel),
    .ld_done(ld_done), .ld_fault(ld_fault), .ld_code(ld_code),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .xr_valid(xr_valid), .xr_ready(xr_ready), .xr_seg(xr_seg), .xr_off(xr_off),
    .xr_size(xr_size), .xr_write(xr_write),
    .xo_valid(xo_valid), .xo_lin(xo_lin), .xo_fault(xo_fault)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] g_w0 [8], g_w1 [8], l_w0 [8], l_w1 [8];
  logic [31:0] sh_base [4], sh_lim [4];
  logic        sh_r [4], sh_w [4];
  int          rd_count = 0;
  logic [31:0] addr_log [2];
  int          fixed_lat = 0;
  bit          stall_ready = 0;

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(logic [31:0] a);
    if (a >= GB && a < GB + 64) return a[2] ? g_w1[(a - GB) >> 3] : g_w0[(a - GB) >> 3];
    if (a >= LB && a < LB + 64) return a[2] ? l_w1[(a - LB) >> 3] : l_w0[(a - LB) >> 3];
    return 32'hDEAD_BEEF;
  endfunction

  // memory model
  initial begin
    bit pend = 0;
    int lat = 0;
    logic [31:0] paddr = 0;
    mem_rsp_valid = 0; mem_rsp_data = 0; mem_rd_ready = 0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 0;
      if (pend) begin
        if (lat == 0) begin
          mem_rsp_valid = 1; mem_rsp_data = mem_word(paddr); pend = 0;
        end else lat--;
      end
      mem_rd_ready = stall_ready ? 1'b0 : (($urandom % 4) != 0);
      if (mem_rd_valid && mem_rd_ready && !pend) begin
        pend = 1; paddr = mem_rd_addr;
        lat = fixed_lat != 0 ? fixed_lat : int'($urandom % 3);
        addr_log[rd_count % 2] = mem_rd_addr;
        rd_count++;
      end
    end
  end

  function automatic logic [1:0] exp_code(int s, logic [31:0] off, logic [1:0] sz, bit wr);
    if (wr ? !sh_w[s] : !sh_r[s]) return 2'd2;
    if (({1'b0, off} + {31'b0, sz}) > {1'b0, sh_lim[s]}) return 2'd1;
    return 2'd0;
  endfunction

  task automatic do_load(int s, logic [15:0] sel);
    int start = rd_count;
    int idx = sel[15:3];
    bit loc = sel[2];
    int cnt = loc ? LCNT : GCNT;
    logic [31:0] a0 = (loc ? LB : GB) + 32'(idx * 8);
    logic [31:0] w0, w1;
    logic [1:0] code;
    int cyc = 0;
    @(negedge clk);
    ld_valid = 1; ld_seg = 2'(s); ld_sel = sel;
    @(negedge clk);
    ld_valid = 0;
    while (!(ld_done || ld_fault) && cyc < 100) begin @(negedge clk); cyc++; end
    code = ld_fault ? ld_code : 2'd0;
    if (idx >= cnt) begin
      chk(ld_fault && code == 1, "R3 range fault code", code, 1);
      chk(rd_count == start, "R3 no memory read", rd_count - start, 0);
      return;
    end
    chk(rd_count - start == 2, "R2 two reads", rd_count - start, 2);
    chk(addr_log[start % 2] == a0 && addr_log[(start + 1) % 2] == a0 + 4,
        "R2 read addresses", addr_log[start % 2], a0);
    w0 = mem_word(a0); w1 = mem_word(a0 + 4);
    if (!w1[0]) begin
      chk(ld_fault && code == 2, "R4 absent fault code", code, 2);
    end else begin
      chk(ld_done && !ld_fault, "R5 load done", {ld_done, ld_fault}, 2'b10);
      sh_base[s] = w0; sh_lim[s] = {w1[31:4], 4'hF}; sh_r[s] = w1[1]; sh_w[s] = w1[2];
    end
  endtask

  task automatic do_xlate(int s, logic [31:0] off, logic [1:0] sz, bit wr);
    int start = rd_count;
    logic [1:0] ec = exp_code(s, off, sz, wr);
    logic [31:0] el = (ec == 0) ? sh_base[s] + off : 32'h0;
    @(negedge clk);
    xr_valid = 1; xr_seg = 2'(s); xr_off = off; xr_size = sz; xr_write = wr;
    @(negedge clk);
    xr_valid = 0;
    chk(xo_valid, "R6 result pulse", xo_valid, 1);
    if (ec == 2) chk(xo_fault == ec && xo_lin == 0, "R8 rights fault", {xo_fault, xo_lin}, {ec, el});
    else if (ec == 1) chk(xo_fault == ec && xo_lin == 0, "R7 limit fault", {xo_fault, xo_lin}, {ec, el});
    else chk(xo_fault == 0 && xo_lin == el, "R6 linear address", {xo_fault, xo_lin}, {ec, el});
    chk(rd_count == start, "R5 cached, no read", rd_count - start, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) begin
      logic [27:0] lh;
      lh = ($urandom % 2) ? 28'($urandom) : 28'($urandom % 16);
      g_w0[i] = $urandom;
      g_w1[i] = {lh, 1'b0, 1'($urandom), 1'($urandom), 1'(i != 5)};
      lh = ($urandom % 2) ? 28'($urandom) : 28'($urandom % 16);
      l_w0[i] = $urandom;
      l_w1[i] = {lh, 1'b0, 1'($urandom), 1'($urandom), 1'(i != 1)};
    end
    g_w0[2] = 32'hFFFF_FF00; g_w1[2] = {28'h0000_0FF, 4'b0111};
    for (int s = 0; s < 4; s++) begin
      sh_base[s] = 0; sh_lim[s] = 32'hFFFF_FFFF; sh_r[s] = 1; sh_w[s] = 1;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(ld_ready && xr_ready && !xo_valid && !ld_done && !ld_fault && !mem_rd_valid,
        "R1 idle outputs", {ld_ready, xr_ready, xo_valid, ld_done, ld_fault, mem_rd_valid}, 6'b110000);
    for (int s = 0; s < 4; s++) begin
      do_xlate(s, 32'hFFFF_FFFC, 2'd3, 1);
      chk(xo_lin == 32'hFFFF_FFFC && xo_fault == 0, "R1 reset flat segment", xo_lin, 32'hFFFF_FFFC);
    end
    do_xlate(1, 32'hFFFF_FFFF, 2'd1, 0); // R1 limit is FFFFFFFFH
    // directed loads: R3 range, R4 absent, R2 local table with RPL bits
    do_load(0, {13'd6, 1'b0, 2'd0});
    do_xlate(0, 32'h10, 0, 1); // R3 register unchanged
    do_load(0, {13'd5, 1'b0, 2'd0});
    do_xlate(0, 32'hFFFF_FFF0, 3, 1); // R4 register unchanged
    do_load(3, {13'd2, 1'b0, 2'd3});
    do_xlate(3, 32'h0000_0200, 0, 0); // R6 wrap: FFFFFF00+200
    do_xlate(3, 32'h0000_0FFF, 0, 0); // R7 last byte
    do_xlate(3, 32'h0000_0FFE, 2'd1, 0); // R7 two bytes ending at limit
    do_xlate(3, 32'h0000_0FFE, 2'd2, 0); // R7 one past
    do_load(2, {13'd3, 1'b1, 2'd1});
    do_load(2, {13'd9, 1'b1, 2'd0});
    // R9 stall during fetch
    fixed_lat = 5;
    @(negedge clk);
    ld_valid = 1; ld_seg = 1; ld_sel = {13'd2, 1'b0, 2'd0};
    @(negedge clk);
    ld_valid = 0; xr_valid = 1; xr_seg = 1; xr_off = 0; xr_size = 0; xr_write = 0;
    #1;
    chk(!xr_ready && !ld_ready, "R9 target stalled", {xr_ready, ld_ready}, 2'b00);
    xr_seg = 0;
    #1;
    chk(xr_ready, "R9 other register ready", xr_ready, 1);
    @(negedge clk);
    xr_valid = 0;
    chk(xo_valid && xo_fault == exp_code(0, 0, 0, 0), "R9 other register translated", xo_fault, exp_code(0, 0, 0, 0));
    while (!ld_done && !ld_fault) @(negedge clk);
    sh_base[1] = g_w0[2]; sh_lim[1] = {g_w1[2][31:4], 4'hF}; sh_r[1] = 1; sh_w[1] = 1;
    fixed_lat = 0;
    do_xlate(1, 32'h100, 3, 1);
    // R10 request held under back-pressure
    stall_ready = 1;
    @(negedge clk);
    ld_valid = 1; ld_seg = 2; ld_sel = {13'd4, 1'b0, 2'd0};
    @(negedge clk);
    ld_valid = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(mem_rd_valid && mem_rd_addr == GB + 32, "R10 held request", mem_rd_addr, GB + 32);
    end
    stall_ready = 0;
    while (!ld_done && !ld_fault) @(negedge clk);
    if (ld_done) begin
      sh_base[2] = g_w0[4]; sh_lim[2] = {g_w1[4][31:4], 4'hF}; sh_r[2] = g_w1[4][1]; sh_w[2] = g_w1[4][2];
    end
    // random mix
    for (int it = 0; it < 400; it++) begin
      int s = int'($urandom % 4);
      if ($urandom % 4 == 0) begin
        do_load(s, {13'($urandom % 8), 1'($urandom), 2'($urandom)});
      end else begin
        logic [31:0] off;
        case ($urandom % 3)
          0: off = $urandom;
          1: off = sh_lim[s] - ($urandom % 5);
          default: off = $urandom % 64;
        endcase
        do_xlate(s, off, 2'($urandom), 1'($urandom));
      end
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule